// File: doc/BRIEF.md
# Fault-injectable bit-wide SRAM model

This block is a one-bit-wide synchronous memory that can take on one functional
defect at run time. It stands in for a real memory when self-test sequencing
logic is being verified: the test engine drives address, write strobe, read
strobe and one data bit, and gets the read bit back one cycle later. A small
write-only register port picks the defect type, a victim address, an aggressor
address and two polarity bits. A reset returns the model to the defect-free
state with every cell cleared.

The defects cover address decoding (an address with no cell, a cell with no
address of its own, one address hitting two cells, one cell hit by two
addresses), single-cell defects (stuck value, failed transition, unreadable
cell behind a latching sense amplifier, leaky cell) and two-cell coupling
(inversion, forcing on a transition, forcing on a held state). Leak time is
counted in clock cycles through a parameter. With no defect selected the model
is an ideal RAM.

Top module: `fsram_model`

## Requirements
- R1: After reset, dout is 0, every cell reads 0 and the defect type is none (code 0). With type none, a read strobe in cycle t returns the addressed cell's content on dout after edge t, a write stores din, and dout holds its value in any cycle without a read strobe. A read in the same cycle as a write returns the old content.
- R2: Type 1 (stuck): the victim reads as polarity V (cfg register 3 bit 0) whatever is written to it; other cells work normally.
- R3: Type 2 (transition): a write to the victim that would move it away from V (V=0: 0 to 1 fails; V=1: 1 to 0 fails) leaves it unchanged; the other direction and non-changing writes work.
- R4: Type 3 (stuck-open): a read of the victim leaves dout at the value of the previous read, and writes to the victim have no effect.
- R5: Type 4 (inversion coupling): a write that moves the aggressor to value A (cfg register 3 bit 1; A=1 rising, A=0 falling) inverts the victim; writes in the other direction or without a change leave the victim alone.
- R6: Type 5 (forcing coupling): a write that moves the aggressor to A sets the victim to V.
- R7: Type 6 (state coupling): whenever the aggressor holds A, the victim is held at V, including against writes to it; when the aggressor leaves A the victim is writable again.
- R8: Type 8 (address without cell): a read of the victim address returns V; a write to it changes no cell.
- R9: Type 9 (cell without address): the victim address reaches the aggressor cell for reads and writes; the victim cell is never touched.
- R10: Type 10 (address to two cells): the victim address writes both the victim and aggressor cells and reads the AND of the two.
- R11: Type 11 (cell with two addresses): the aggressor address reaches the victim cell instead of its own; the aggressor cell is never touched.
- R12: Type 7 (retention): when the victim holds V and is not written for RET_CYCLES cycles it flips to the other value once; any write to it restarts the count, and a victim holding the other value never flips.
- R13: Configuration registers are written with cfg_wr, selected by cfg_sel (0 type, 1 victim address, 2 aggressor address, 3 polarity: bit 0 V, bit 1 A) and take effect from the next cycle; reset clears them to type none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | input | ADDR_W | Memory address |
| mem_we | input | 1 | Write strobe |
| mem_re | input | 1 | Read strobe |
| mem_din | input | 1 | Write data bit |
| mem_dout | output | 1 | Read data bit, registered |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | max(ADDR_W,4) | Configuration write data |

## Verification
A table of writes and reads over a checkerboard and its inverse first shows the defect-free model stores each bit independently and returns it with one cycle of latency. Each defect is then driven with writes that do and do not change the aggressor or victim, in both directions, so a trigger on the wrong edge, a missed transition or a wrong forced value shows up in a later read. For the decoder defects, switching back to type none after the faulty accesses shows which physical cells were actually written. The retention case reads before and after the hold interval and after a refreshing write, telling a correct count apart from one that ignores writes or flips the wrong value.

// File: rtl/fsram_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the fault-injectable SRAM model.
package fsram_pkg;
    typedef enum logic [3:0] {
        FT_NONE      = 4'd0,
        FT_STUCK     = 4'd1,
        FT_TRANS     = 4'd2,
        FT_OPEN      = 4'd3,
        FT_CINV      = 4'd4,
        FT_CFORCE    = 4'd5,
        FT_CSTATE    = 4'd6,
        FT_RETAIN    = 4'd7,
        FT_A_NOCELL  = 4'd8,
        FT_A_NOADDR  = 4'd9,
        FT_A_TWOCELL = 4'd10,
        FT_A_TWOADDR = 4'd11
    } fault_e;
endpackage

// File: rtl/fsram_cfg.sv
`timescale 1ns/1ps
// Configuration registers: fault type, victim, aggressor, polarity bits.
// Assumes cfg_wdata is at least 4 bits and at least ADDR_W bits wide.
module fsram_cfg
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int CFG_DW = (ADDR_W > 4) ? ADDR_W : 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output fault_e            ftype,
    output logic [ADDR_W-1:0] vic,
    output logic [ADDR_W-1:0] agg,
    output logic              pol_v,
    output logic              pol_a
);
    // Register update on a selected configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftype <= FT_NONE;
            vic   <= '0;
            agg   <= '0;
            pol_v <= 1'b0;
            pol_a <= 1'b0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                2'd0: ftype <= fault_e'(cfg_wdata[3:0]);
                2'd1: vic   <= cfg_wdata[ADDR_W-1:0];
                2'd2: agg   <= cfg_wdata[ADDR_W-1:0];
                default: begin
                    pol_v <= cfg_wdata[0];
                    pol_a <= cfg_wdata[1];
                end
            endcase
        end
    end

    // R13: a type write lands one cycle later
    a_r13_type_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 2'd0) |=> (ftype == fault_e'($past(cfg_wdata[3:0]))));
endmodule

// File: rtl/fsram_decode.sv
`timescale 1ns/1ps
// Address decoder with optional decoder fault. Produces a one-hot (or
// zero- or two-hot under decoder faults) cell select vector.
// Assumes victim and aggressor differ when a decoder fault is active.
module fsram_decode
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int CELLS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  fault_e            ftype,
    input  logic [ADDR_W-1:0] vic,
    input  logic [ADDR_W-1:0] agg,
    output logic [CELLS-1:0]  sel
);
    logic hit_vic, hit_agg;
    assign hit_vic = (addr == vic);
    assign hit_agg = (addr == agg);

    for (genvar i = 0; i < CELLS; i++) begin : g_sel
        logic own, is_v, is_a;
        assign own  = (addr == ADDR_W'(i));
        assign is_v = (vic  == ADDR_W'(i));
        assign is_a = (agg  == ADDR_W'(i));
        // Per-cell select under the configured decoder behaviour.
        always_comb begin
            case (ftype)
                FT_A_NOCELL:  sel[i] = own && !hit_vic;
                FT_A_NOADDR:  sel[i] = hit_vic ? is_a : own;
                FT_A_TWOCELL: sel[i] = own || (hit_vic && is_a);
                FT_A_TWOADDR: sel[i] = hit_agg ? is_v : own;
                default:      sel[i] = own;
            endcase
        end
    end

    // R8: the faulty address selects nothing
    a_r8_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (ftype == FT_A_NOCELL && hit_vic) |-> (sel == '0));
    // R10: at most two cells are ever selected
    a_r10_two_max: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel) <= 2));
    // R11: outside the two-cell fault a single cell at most
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ftype != FT_A_TWOCELL) |-> $onehot0(sel));
endmodule

// File: rtl/fsram_retain.sv
`timescale 1ns/1ps
// Retention timer: counts idle cycles while the victim holds the leaking
// value and pulses decay when RET_CYCLES have passed without a write.
module fsram_retain #(
    parameter int RET_CYCLES = 1000,
    localparam int CNT_W = $clog2(RET_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cell_val,
    input  logic hold_val,
    input  logic touched,
    output logic decay
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    assign armed = enable && (cell_val == hold_val) && !touched;
    assign decay = armed && (cnt == CNT_W'(RET_CYCLES - 1));

    // Idle-cycle counter, cleared by a write, a decay or a disarm.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || decay) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R12: count stays inside the interval
    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < CNT_W'(RET_CYCLES)));
endmodule

// File: rtl/fsram_core.sv
`timescale 1ns/1ps
// Cell array with cell and coupling fault effects and the registered
// read path with a latching sense amplifier. Assumes victim and aggressor
// addresses differ for coupling faults.
module fsram_core
    import fsram_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RET_CYCLES = 1000,
    localparam int CELLS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CELLS-1:0]  sel,
    input  logic              we,
    input  logic              re,
    input  logic              din,
    input  fault_e            ftype,
    input  logic [ADDR_W-1:0] vic,
    input  logic [ADDR_W-1:0] agg,
    input  logic              pol_v,
    input  logic              pol_a,
    output logic              dout
);
    logic [CELLS-1:0] cells, nxt, view;
    logic             decay, trig, open_hit, rd_val, vic_written;

    assign vic_written = we && sel[vic];
    assign open_hit    = (ftype == FT_OPEN) && sel[vic];
    assign trig        = we && sel[agg] && (cells[agg] != din) && (din == pol_a);

    fsram_retain #(.RET_CYCLES(RET_CYCLES)) u_retain (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ftype == FT_RETAIN),
        .cell_val (cells[vic]),
        .hold_val (pol_v),
        .touched  (vic_written),
        .decay    (decay)
    );

    // Read view: a stuck victim always presents the stuck value.
    for (genvar i = 0; i < CELLS; i++) begin : g_view
        assign view[i] = (ftype == FT_STUCK && vic == ADDR_W'(i)) ? pol_v : cells[i];
    end

    // Read value: wired-AND of selected cells, floating value if none.
    assign rd_val = (|sel) ? &(view | ~sel) : pol_v;

    // Next cell state: writes, then coupling, forcing and decay effects.
    always_comb begin
        nxt = cells;
        for (int i = 0; i < CELLS; i++) begin
            if (we && sel[i]) begin
                if (ADDR_W'(i) != vic) nxt[i] = din;
                else if (ftype == FT_STUCK || ftype == FT_OPEN) nxt[i] = cells[i];
                else if (ftype == FT_TRANS && cells[i] == pol_v && din != pol_v)
                    nxt[i] = cells[i];
                else nxt[i] = din;
            end
        end
        if (trig && ftype == FT_CINV)   nxt[vic] = ~cells[vic];
        if (trig && ftype == FT_CFORCE) nxt[vic] = pol_v;
        if (ftype == FT_CSTATE && nxt[agg] == pol_a) nxt[vic] = pol_v;
        if (ftype == FT_STUCK) nxt[vic] = pol_v;
        if (decay) nxt[vic] = ~pol_v;
    end

    // Cell storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cells <= '0;
        else        cells <= nxt;
    end

    // Output latch: updated by reads except of a stuck-open victim.
    always_ff @(posedge clk) begin
        if (!rst_n)                dout <= 1'b0;
        else if (re && !open_hit)  dout <= rd_val;
    end

    // R1: no read strobe, no output change
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(dout));
    // R4: a stuck-open read replays the previous value
    a_r4_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (re && open_hit) |=> $stable(dout));
    // R2: a stuck victim reads its stuck value
    a_r2_stuck_read: assert property (@(posedge clk) disable iff (!rst_n)
        (re && ftype == FT_STUCK && sel[vic]) |=> (dout == $past(pol_v)));
    // R7: victim held while the aggressor is in the active state
    a_r7_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ftype == FT_CSTATE && nxt[agg] == pol_a && vic != agg) |=> (cells[vic] == $past(pol_v)));
endmodule

// File: rtl/fsram_model.sv
`timescale 1ns/1ps
// Top of the fault-injectable one-bit SRAM model: configuration registers,
// faulty decoder and faulty cell array with a one-cycle read.
module fsram_model
    import fsram_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RET_CYCLES = 1000,
    localparam int CFG_DW = (ADDR_W > 4) ? ADDR_W : 4,
    localparam int CELLS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  logic              mem_re,
    input  logic              mem_din,
    output logic              mem_dout,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_DW-1:0] cfg_wdata
);
    fault_e            ftype;
    logic [ADDR_W-1:0] vic, agg;
    logic              pol_v, pol_a;
    logic [CELLS-1:0]  sel;

    fsram_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ftype(ftype), .vic(vic), .agg(agg),
        .pol_v(pol_v), .pol_a(pol_a)
    );

    fsram_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .addr(mem_addr), .ftype(ftype),
        .vic(vic), .agg(agg), .sel(sel)
    );

    fsram_core #(.ADDR_W(ADDR_W), .RET_CYCLES(RET_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(mem_we), .re(mem_re),
        .din(mem_din), .ftype(ftype), .vic(vic), .agg(agg),
        .pol_v(pol_v), .pol_a(pol_a), .dout(mem_dout)
    );
endmodule

// File: tb/fsram_model_bench.sv
`timescale 1ns/1ps
module fsram_model_bench;
    localparam int AW  = 4;
    localparam int RET = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_we = 1'b0, mem_re = 1'b0, mem_din = 1'b0;
    logic          mem_dout;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [3:0]    cfg_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fsram_model #(.ADDR_W(AW), .RET_CYCLES(RET)) u_fsram_model (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_din(mem_din), .mem_dout(mem_dout),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    // Vector table for the ideal RAM: {write, addr[3:0], data}; reads expect data.
    localparam logic [5:0] VEC [0:15] = '{
        6'b1_0000_1, 6'b1_0001_0, 6'b1_0010_1, 6'b1_0011_0,
        6'b0_0000_1, 6'b0_0001_0, 6'b0_0010_1, 6'b0_0011_0,
        6'b1_0000_0, 6'b1_0001_1, 6'b1_0010_0, 6'b1_0011_1,
        6'b0_0011_1, 6'b0_0010_0, 6'b0_0001_1, 6'b0_0000_0
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [3:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic setup(input logic [3:0] t, input logic [3:0] v,
                         input logic [3:0] a, input logic pa, input logic pv);
        do_reset();
        cfg(2'd1, v); cfg(2'd2, a); cfg(2'd3, {2'b00, pa, pv}); cfg(2'd0, t);
    endtask

    task automatic wr(input logic [3:0] a, input logic d);
        @(negedge clk); mem_addr = a; mem_din = d; mem_we = 1'b1;
        @(negedge clk); mem_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic exp, input string tag);
        @(negedge clk); mem_addr = a; mem_re = 1'b1;
        @(negedge clk); mem_re = 1'b0;
        check(mem_dout, exp, tag);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check(mem_dout, 1'b0, "R1 reset dout");
        rd(4'd5, 1'b0, "R1 reset cell");

        // R1 vector walk
        for (int k = 0; k < 16; k++) begin
            if (VEC[k][5]) wr(VEC[k][4:1], VEC[k][0]);
            else           rd(VEC[k][4:1], VEC[k][0], "R1 vector read");
        end
        // R1 hold with no read strobe, read-before-write
        wr(4'd7, 1'b1);
        idle(2);
        check(mem_dout, 1'b0, "R1 dout held");
        @(negedge clk); mem_addr = 4'd7; mem_din = 1'b0; mem_we = 1'b1; mem_re = 1'b1;
        @(negedge clk); mem_we = 1'b0; mem_re = 1'b0;
        check(mem_dout, 1'b1, "R1 old data on collision");
        rd(4'd7, 1'b0, "R1 write after collision");

        // R2 stuck
        setup(4'd1, 4'd3, 4'd0, 1'b0, 1'b1);
        wr(4'd3, 1'b0); rd(4'd3, 1'b1, "R2 stuck at 1");
        wr(4'd4, 1'b1); rd(4'd4, 1'b1, "R2 neighbour");
        cfg(2'd3, 4'd0);
        wr(4'd3, 1'b1); rd(4'd3, 1'b0, "R2 stuck at 0");

        // R13 reset clears configuration
        do_reset();
        wr(4'd3, 1'b1); rd(4'd3, 1'b1, "R13 reset to none");

        // R3 transition
        setup(4'd2, 4'd6, 4'd0, 1'b0, 1'b0);
        wr(4'd6, 1'b1); rd(4'd6, 1'b0, "R3 rise fails");
        cfg(2'd3, 4'd1);
        wr(4'd6, 1'b1); rd(4'd6, 1'b1, "R3 rise ok");
        wr(4'd6, 1'b0); rd(4'd6, 1'b1, "R3 fall fails");

        // R4 stuck-open
        setup(4'd3, 4'd7, 4'd0, 1'b0, 1'b0);
        wr(4'd2, 1'b1); rd(4'd2, 1'b1, "R4 prep");
        rd(4'd7, 1'b1, "R4 replay 1");
        wr(4'd7, 1'b1);
        wr(4'd8, 1'b0); rd(4'd8, 1'b0, "R4 prep 0");
        rd(4'd7, 1'b0, "R4 replay 0");
        cfg(2'd0, 4'd0);
        rd(4'd7, 1'b0, "R4 write ignored");

        // R5 inversion coupling, rising trigger
        setup(4'd4, 4'd9, 4'd2, 1'b1, 1'b0);
        wr(4'd2, 1'b1); rd(4'd9, 1'b1, "R5 rise inverts");
        wr(4'd2, 1'b1); wr(4'd2, 1'b0); rd(4'd9, 1'b1, "R5 no trigger");
        wr(4'd2, 1'b1); rd(4'd9, 1'b0, "R5 second inversion");

        // R6 forcing coupling, falling trigger, force 1
        setup(4'd5, 4'd9, 4'd2, 1'b0, 1'b1);
        wr(4'd2, 1'b1); rd(4'd9, 1'b0, "R6 rise no effect");
        wr(4'd2, 1'b0); rd(4'd9, 1'b1, "R6 fall forces");
        wr(4'd9, 1'b0); wr(4'd2, 1'b0); rd(4'd9, 1'b0, "R6 no change no force");

        // R7 state coupling: aggressor at 1 holds victim at 0
        setup(4'd6, 4'd10, 4'd11, 1'b1, 1'b0);
        wr(4'd10, 1'b1); rd(4'd10, 1'b1, "R7 inactive");
        wr(4'd11, 1'b1); rd(4'd10, 1'b0, "R7 forced");
        wr(4'd10, 1'b1); rd(4'd10, 1'b0, "R7 write blocked");
        wr(4'd11, 1'b0); wr(4'd10, 1'b1); rd(4'd10, 1'b1, "R7 released");

        // R8 address without cell
        setup(4'd8, 4'd12, 4'd0, 1'b0, 1'b1);
        rd(4'd12, 1'b1, "R8 float 1");
        wr(4'd12, 1'b0); rd(4'd12, 1'b1, "R8 write lost");
        wr(4'd12, 1'b1);
        cfg(2'd3, 4'd0); rd(4'd12, 1'b0, "R8 float 0");
        cfg(2'd0, 4'd0); rd(4'd12, 1'b0, "R8 cell untouched");

        // R9 victim address reaches aggressor cell
        setup(4'd9, 4'd4, 4'd13, 1'b0, 1'b0);
        wr(4'd13, 1'b1); rd(4'd4, 1'b1, "R9 read redirected");
        wr(4'd4, 1'b0); rd(4'd13, 1'b0, "R9 write redirected");
        wr(4'd4, 1'b1);
        cfg(2'd0, 4'd0); rd(4'd4, 1'b0, "R9 victim untouched");

        // R10 one address, two cells
        setup(4'd10, 4'd5, 4'd14, 1'b0, 1'b0);
        wr(4'd14, 1'b1); rd(4'd5, 1'b0, "R10 wired AND");
        wr(4'd5, 1'b1); rd(4'd5, 1'b1, "R10 both written");
        rd(4'd14, 1'b1, "R10 aggressor written");
        wr(4'd14, 1'b0); rd(4'd5, 1'b0, "R10 AND low");

        // R11 two addresses, one cell
        setup(4'd11, 4'd5, 4'd14, 1'b0, 1'b0);
        wr(4'd14, 1'b1); rd(4'd5, 1'b1, "R11 victim via aggressor");
        rd(4'd14, 1'b1, "R11 aggressor reads victim");
        cfg(2'd0, 4'd0); rd(4'd14, 1'b0, "R11 aggressor cell untouched");

        // R12 retention, leaking value 1
        setup(4'd7, 4'd15, 4'd0, 1'b0, 1'b1);
        wr(4'd15, 1'b1); idle(5); rd(4'd15, 1'b1, "R12 before interval");
        idle(30); rd(4'd15, 1'b0, "R12 after interval");
        idle(30); rd(4'd15, 1'b0, "R12 other value kept");
        wr(4'd15, 1'b1); idle(12); wr(4'd15, 1'b1); idle(12);
        rd(4'd15, 1'b1, "R12 refresh restarts");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule